// File: doc/BRIEF.md
# Serial Joystick Port Poller

This block reads two digital joysticks through a small external converter that turns twelve switch lines into a serial stream. The block owns the serial clock line and receives one data line back from the converter. It runs on its own, with no host request. Each poll leaves the clock low for a long idle gap, which makes the converter sample its switches again. It then sends a burst of clock pulses and collects the sixteen returned bits into a packet.

The converter moves to its next bit just after each rising clock edge. The block therefore reads each bit at the rising edge that follows. The first rising edge of a burst only wakes the converter. A burst has 17 rising edges, and bits are taken on edges 2 through 17.

Within a packet, each joystick fills one byte with six switch bits followed by two guard bits that must read zero. The block inverts the switch bits, because a pressed switch pulls its line low, and presents two 6-bit button words. A packet whose guard bits are not both zero is dropped and flagged. A good packet updates the outputs and raises a one-cycle valid strobe. The outputs keep their last good value in between.

Top module: `joy_poll`

## Requirements
- R1: Before every burst, including the first burst after reset, `joy_clk` stays low for at least IDLE_CYC consecutive clock cycles.
- R2: Each burst has exactly 17 rising edges on `joy_clk`. Within a burst, every high phase and every low phase lasts exactly HALF_CYC cycles.
- R3: The received bit taken at rising edge k (k = 2..17) becomes packet bit k-2. Packet bits 0..5 belong to joystick A and bits 8..13 to joystick B. In both groups the switches come in the order up, down, left, right, fire1, fire2.
- R4: Output bit i of `joy_a` and `joy_b` (0=up, 1=down, 2=left, 3=right, 4=fire1, 5=fire2) is the inverse of the matching packet bit, so a line read as 0 gives 1 (pressed).
- R5: When any of packet bits 6, 7, 14 or 15 reads 1, `pkt_err` pulses for one cycle, `pkt_valid` stays low, and `joy_a`/`joy_b` keep their previous values.
- R6: When a good packet completes, `pkt_valid` pulses high for exactly one cycle, in the same cycle that `joy_a`/`joy_b` take their new value. The outputs change at no other time, and `pkt_valid` and `pkt_err` are never high together.
- R7: While reset is asserted and right after it, `joy_clk` is low, `joy_a`/`joy_b` are zero, and `pkt_valid`/`pkt_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| joy_clk | output | 1 | Serial clock to the converter |
| joy_data | input | 1 | Serial data from the converter, asynchronous |
| joy_a | output | 6 | Joystick A buttons, active high |
| joy_b | output | 6 | Joystick B buttons, active high |
| pkt_valid | output | 1 | One-cycle strobe marking a new good packet |
| pkt_err | output | 1 | One-cycle strobe marking a dropped packet |

## Verification
The bench builds the block with HALF_CYC=3, IDLE_CYC=40 and a two-stage input synchroniser. This shrinks a poll from tens of thousands of cycles to about 150, so forty packets fit in a short run. At this size the per-phase cycle counts, the 17-edge burst and the idle gap can all be measured exactly at the pin. The synchroniser delay is still shorter than a low phase, as it is at the default sizes. Random button patterns are mixed with directed cases: all pressed, none pressed, and a guard-bit fault in each joystick byte.

// File: rtl/joy_pkg.sv
package joy_pkg;
    localparam int PKT_BITS = 16;
    localparam int EDGES    = PKT_BITS + 1;
    localparam int BTN_W    = 6;
    localparam int IDX_W    = $clog2(PKT_BITS);
    localparam int EDGE_W   = $clog2(EDGES + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/joy_sync.sv
module joy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/joy_clkgen.sv
module joy_clkgen
    import joy_pkg::*;
#(
    parameter int HALF_CYC = 1000,
    parameter int IDLE_CYC = 40000
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sclk,
    output logic             cap,
    output logic [IDX_W-1:0] cap_idx
);
    localparam int MAXC = (IDLE_CYC > HALF_CYC) ? IDLE_CYC : HALF_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0]     IDLE_LAST = CW'(IDLE_CYC - 1);
    localparam logic [CW-1:0]     HALF_LAST = CW'(HALF_CYC - 1);
    localparam logic [EDGE_W-1:0] EDGE_END  = EDGE_W'(EDGES);

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [EDGE_W-1:0] edge_no;
        logic              sclk;
        logic              cap;
        logic [IDX_W-1:0]  idx;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d     = gen_q;
        gen_d.cap = 1'b0;
        case (gen_q.phase)
            PH_IDLE: begin
                if (gen_q.cnt == IDLE_LAST) begin
                    gen_d.phase   = PH_HIGH;
                    gen_d.cnt     = '0;
                    gen_d.sclk    = 1'b1;
                    gen_d.edge_no = EDGE_W'(1);
                end else begin
                    gen_d.cnt = gen_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (gen_q.cnt == HALF_LAST) begin
                    gen_d.cnt   = '0;
                    gen_d.sclk  = 1'b0;
                    gen_d.phase = (gen_q.edge_no == EDGE_END) ? PH_IDLE : PH_LOW;
                end else begin
                    gen_d.cnt = gen_q.cnt + 1'b1;
                end
            end
            PH_LOW: begin
                if (gen_q.cnt == HALF_LAST) begin
                    gen_d.cnt     = '0;
                    gen_d.sclk    = 1'b1;
                    gen_d.phase   = PH_HIGH;
                    gen_d.edge_no = gen_q.edge_no + 1'b1;
                    gen_d.cap     = 1'b1;
                    gen_d.idx     = IDX_W'(gen_q.edge_no - 1'b1);
                end else begin
                    gen_d.cnt = gen_q.cnt + 1'b1;
                end
            end
            default: gen_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '{phase: PH_IDLE, cnt: '0, edge_no: '0,
                       sclk: 1'b0, cap: 1'b0, idx: '0};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign sclk    = gen_q.sclk;
    assign cap     = gen_q.cap;
    assign cap_idx = gen_q.idx;

    assert_edge_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q.edge_no <= EDGE_END);
    assert_cap_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q.cap |-> $rose(gen_q.sclk));
    assert_low_after_burst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gen_q.sclk) && gen_q.edge_no == EDGE_END) |=> !gen_q.sclk);
endmodule

// File: rtl/joy_assemble.sv
module joy_assemble
    import joy_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             din,
    output logic [BTN_W-1:0] btn_a,
    output logic [BTN_W-1:0] btn_b,
    output logic             valid,
    output logic             err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BITS - 1);

    typedef struct packed {
        logic [PKT_BITS-1:0] bits;
        logic [BTN_W-1:0]    a;
        logic [BTN_W-1:0]    b;
        logic                valid;
        logic                err;
    } asm_t;

    asm_t asm_d, asm_q;
    logic [PKT_BITS-1:0] word;
    logic                guard_bad;

    always_comb begin
        asm_d       = asm_q;
        asm_d.valid = 1'b0;
        asm_d.err   = 1'b0;
        word        = asm_q.bits;
        guard_bad   = 1'b0;
        if (cap) begin
            word[cap_idx] = din;
            asm_d.bits    = word;
            if (cap_idx == LAST_IDX) begin
                guard_bad = word[6] | word[7] | word[14] | word[15];
                if (guard_bad) begin
                    asm_d.err = 1'b1;
                end else begin
                    asm_d.a     = ~word[BTN_W-1:0];
                    asm_d.b     = ~word[8 +: BTN_W];
                    asm_d.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) asm_q <= '0;
        else        asm_q <= asm_d;
    end

    assign btn_a = asm_q.a;
    assign btn_b = asm_q.b;
    assign valid = asm_q.valid;
    assign err   = asm_q.err;

    assert_one_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({asm_q.valid, asm_q.err}));
    assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(asm_q.a) || !$stable(asm_q.b)) |-> asm_q.valid);
    assert_short_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        asm_q.valid |=> !asm_q.valid);
    assert_err_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        asm_q.err |-> ($stable(asm_q.a) && $stable(asm_q.b)));
endmodule

// File: rtl/joy_poll.sv
module joy_poll
    import joy_pkg::*;
#(
    parameter int HALF_CYC    = 1000,
    parameter int IDLE_CYC    = 40000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             joy_clk,
    input  logic             joy_data,
    output logic [BTN_W-1:0] joy_a,
    output logic [BTN_W-1:0] joy_b,
    output logic             pkt_valid,
    output logic             pkt_err
);
    logic             data_s;
    logic             cap;
    logic [IDX_W-1:0] cap_idx;

    joy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (joy_data),
        .dout (data_s)
    );

    joy_clkgen #(.HALF_CYC(HALF_CYC), .IDLE_CYC(IDLE_CYC)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (joy_clk),
        .cap    (cap),
        .cap_idx(cap_idx)
    );

    joy_assemble u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .cap_idx(cap_idx),
        .din    (data_s),
        .btn_a  (joy_a),
        .btn_b  (joy_b),
        .valid  (pkt_valid),
        .err    (pkt_err)
    );
endmodule

// File: tb/joy_poll_test.sv
module joy_poll_test;
    localparam int HALF = 3;
    localparam int IDLE = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       joy_clk;
    logic       joy_data = 1'b1;
    logic [5:0] joy_a, joy_b;
    logic       pkt_valid, pkt_err;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    joy_poll #(.HALF_CYC(HALF), .IDLE_CYC(IDLE), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .joy_clk(joy_clk), .joy_data(joy_data),
        .joy_a(joy_a), .joy_b(joy_b), .pkt_valid(pkt_valid), .pkt_err(pkt_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_btn(input logic [15:0] p, input int joy);
        return ~p[joy*8 +: 6];
    endfunction

    function automatic bit exp_bad(input logic [15:0] p);
        return p[6] | p[7] | p[14] | p[15];
    endfunction

    // converter model
    logic [15:0] next_pkt = 16'h3F3F;
    logic [15:0] cur_pkt  = 16'h3F3F;
    logic        prev_clk = 1'b0;
    int          low_run = 0, high_run = 0, edges = 0;
    bit          started = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_clk = 1'b0; low_run = 0; high_run = 0; edges = 0; started = 0;
            joy_data = 1'b1;
        end else begin
            if (joy_clk && !prev_clk) begin
                if (low_run >= IDLE / 2) begin
                    if (started) chk(edges == 17, "R2 edges per burst", edges, 17);
                    chk(low_run >= IDLE, "R1 idle gap", low_run, IDLE);
                    cur_pkt  = next_pkt;
                    edges    = 1;
                    joy_data = cur_pkt[0];
                    started  = 1;
                end else begin
                    chk(low_run == HALF, "R2 low phase", low_run, HALF);
                    edges++;
                    joy_data = (edges <= 16) ? cur_pkt[edges-1] : 1'b1;
                end
                high_run = 1;
            end else if (joy_clk) begin
                high_run++;
            end else if (prev_clk) begin
                chk(high_run == HALF, "R2 high phase", high_run, HALF);
                low_run = 1;
            end else begin
                low_run++;
            end
            prev_clk = joy_clk;
        end
    end

    initial begin
        logic [5:0] last_a = 6'h0, last_b = 6'h0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(joy_clk == 1'b0, "R7 clock low in reset", joy_clk, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(joy_clk == 1'b0, "R7 clock low", joy_clk, 0);
        chk(joy_a == 6'h0 && joy_b == 6'h0, "R7 buttons zero", {joy_a, joy_b}, 0);
        chk(!pkt_valid && !pkt_err, "R7 strobes low", {pkt_valid, pkt_err}, 0);

        for (int i = 0; i < 40; i++) begin
            logic [15:0] p;
            int waited;
            case (i)
                0: p = 16'h0000;
                1: p = 16'h3F3F;
                2: p = 16'h0040;
                3: p = 16'h8000;
                4: p = 16'h3F1F;
                5: p = 16'h3E3F;
                default: begin
                    p = 16'($urandom) & 16'h3F3F;
                    if ($urandom % 6 == 0) p[6 + 8 * ($urandom % 2) + ($urandom % 2)] = 1'b1;
                end
            endcase
            next_pkt = p;
            waited = 0;
            // skip results of the packet currently in flight
            while (!(started && cur_pkt === p && edges == 17 && (pkt_valid || pkt_err))
                   && waited < 2000) begin
                @(negedge clk);
                waited++;
            end
            chk(waited < 2000, "R6 result timeout", waited, 0);
            if (exp_bad(p)) begin
                chk(pkt_err && !pkt_valid, "R5 error flagged", {pkt_valid, pkt_err}, 1);
                chk(joy_a == last_a && joy_b == last_b, "R5 outputs kept",
                    {joy_a, joy_b}, {last_a, last_b});
            end else begin
                chk(pkt_valid && !pkt_err, "R6 valid strobe", {pkt_valid, pkt_err}, 2);
                chk(joy_a == exp_btn(p, 0), "R3 R4 joystick A", joy_a, exp_btn(p, 0));
                chk(joy_b == exp_btn(p, 1), "R3 R4 joystick B", joy_b, exp_btn(p, 1));
                last_a = exp_btn(p, 0);
                last_b = exp_btn(p, 1);
            end
            @(negedge clk);
            chk(!pkt_valid && !pkt_err, "R6 one-cycle strobe", {pkt_valid, pkt_err}, 0);
            chk(joy_a == last_a && joy_b == last_b, "R6 outputs hold",
                {joy_a, joy_b}, {last_a, last_b});
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule